// File: doc/BRIEF.md
# Two-Stage Locked Watchdog Timer

This block is a watchdog with two countdown stages that run one after the other. Software sets a preload value for each stage. Once the block is enabled, the first stage counts down on a slow tick. When it runs out it can raise an interrupt in one of three styles, or none. The second stage then counts down, and when it runs out the block drives a system-reset request and sets a timeout flag. The flag is kept through that system reset, so software can later see why the machine restarted. Software prevents expiry by periodically writing a keepalive bit, which restarts both stages from their preloads.

The two preload registers and the reload register are protected. A write to any of them takes effect only after a two-write key sequence on the reload register, and each completed sequence admits exactly one such write. A separate lock register enables the block and chooses watchdog or periodic-timer mode. It also holds a lock bit: once that bit is set, the lock register cannot be changed until the next reset, so a running watchdog cannot be stopped. The tick comes from the clock through a prescaler, and a configuration bit selects one of two divide ratios.

The register bus is a flat single-cycle port with no handshake. A write is taken on the rising edge while `bus_sel` and `bus_we` are high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_we` is low, and is zero otherwise. There is no back-pressure.

Top module: `dual_stage_watchdog`

## Requirements
- R1: After reset, both preload registers read PRE_INIT (15360, which is 30 s at 512 ticks per second). The status (0x08), reload (0x0C), config (0x10) and lock (0x14) registers read 0. `irq_o`, `nmi_o` and `wdt_rst_o` are low.
- R2: Writing 0x80 and then 0x86 to the reload register (0x0C) opens the guard for exactly one write to a protected register. The protected registers are 0x00 (stage-1 preload), 0x04 (stage-2 preload) and 0x0C (reload). A further 0x80 written after the first step keeps the sequence armed.
- R3: A write to a protected register while the guard is not open is discarded. After 0x80, a write of any value other than 0x80 or 0x86 to a protected register is discarded and returns the guard to its locked state.
- R4: In watchdog mode, stage 1 expires D·P1 cycles after the enabling or keepalive write, where P1 is the stage-1 preload and D is the tick period. On expiry, status bit 0 is set unless config bits 1:0 are 11. Those bits select the interrupt style: 00 drives `irq_o` high for as long as status bit 0 is set; 01 gives a one-cycle `irq_o` pulse; 10 drives `nmi_o` high for as long as status bit 0 is set; 11 gives nothing.
- R5: Stage 2 expires D·(P1+P2) cycles after that write, where P2 is the stage-2 preload. Expiry sets the timeout flag (reload bit 9). While config bit 5 is 0, expiry also raises `wdt_rst_o`, which stays high until a keepalive, a disable or a reset. With config bit 5 set to 1, `wdt_rst_o` stays low but the flag is still set.
- R6: A guarded write with reload bit 8 set restarts stage 1 from the current preloads and restarts the tick divider. The same write made without the guard open has no effect on the timing.
- R7: The timeout flag is kept through `rst_n`. It is cleared by `por_n` or by a guarded write of 1 to reload bit 9. An unguarded write of the same value leaves it set.
- R8: Lock register bits are: bit 1 enable, bit 0 lock, bit 2 mode. Once bit 0 is set, every write to the lock register is ignored, and the register reads back unchanged until reset.
- R9: While the enable bit is 0, nothing expires and all three outputs stay low. Each stage holds its preload, so enabling the block starts a full stage 1.
- R10: The tick period D is 2^SLOW_SHIFT cycles when config bit 2 is 0, and 2^FAST_SHIFT cycles when config bit 2 is 1.
- R11: With lock bit 2 set (timer mode), stage 1 reloads itself on every expiry, once every D·P1 cycles. Stage 2 never runs, `wdt_rst_o` stays low and the timeout flag is left unchanged.
- R12: Writing 1 to status bit 0 (0x08) clears it without the guard, and this drops a level interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything, including the timeout flag |
| rst_n | input | 1 | System reset, active low; clears everything except the timeout flag |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data; combinational, zero when no read is in progress |
| irq_o | output | 1 | Stage-1 interrupt (level or pulse style) |
| nmi_o | output | 1 | Stage-1 interrupt, non-maskable style |
| wdt_rst_o | output | 1 | System-reset request after stage 2 expires |

## Verification
A register write shows on the read port one cycle after its write edge. The bench reads it back with a separate access.

Stage-1 status and interrupts update on the clock edge D·P1 cycles after the edge that took the enabling or keepalive write. `wdt_rst_o` rises D·(P1+P2) cycles after that edge. The bench therefore counts falling edges from the end of that write until each output rises, and compares the counts with these products over a sweep of preloads and both tick rates.

Outputs are always sampled on falling edges. No bus access is made inside a timed window unless the cycles it takes are counted into the window.

// File: rtl/dsw_pkg.sv
`timescale 1ns/1ps
package dsw_pkg;

  typedef enum logic [1:0] {
    STG_IDLE  = 2'd0,
    STG_ONE   = 2'd1,
    STG_TWO   = 2'd2,
    STG_FIRED = 2'd3
  } stage_e;

  typedef enum logic [1:0] {
    GRD_SHUT = 2'd0,
    GRD_HALF = 2'd1,
    GRD_OPEN = 2'd2
  } guard_e;

  typedef enum logic [1:0] {
    IRQ_LEVEL = 2'b00,
    IRQ_PULSE = 2'b01,
    IRQ_NMI   = 2'b10,
    IRQ_NONE  = 2'b11
  } irq_kind_e;

  // register byte offsets
  localparam int OFS_PRE1 = 0;
  localparam int OFS_PRE2 = 4;
  localparam int OFS_STAT = 8;
  localparam int OFS_RLD  = 12;
  localparam int OFS_CFG  = 16;
  localparam int OFS_LOCK = 20;

  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_ARM  = 16'h0080;
  localparam logic [KEY_W-1:0] KEY_OPEN = 16'h0086;

  // bit positions
  localparam int BIT_KICK  = 8;
  localparam int BIT_FLAG  = 9;
  localparam int BIT_NORST = 5;
  localparam int BIT_FAST  = 2;
  localparam int BIT_LOCK  = 0;
  localparam int BIT_EN    = 1;
  localparam int BIT_MODE  = 2;
  localparam int BIT_STAT  = 0;

endpackage

// File: rtl/dsw_unlock_guard.sv
`timescale 1ns/1ps
// Two-write key sequence that admits one protected write per completion.
module dsw_unlock_guard
  import dsw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_key,    // write to the reload register
  input  logic [KEY_W-1:0] key_data,
  input  logic             wr_prot,   // write to any protected register
  output logic             open_o,
  output logic             accept_o
);

  guard_e state;

  assign open_o   = (state == GRD_OPEN);
  assign accept_o = open_o & wr_prot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= GRD_SHUT;
    end else begin
      unique case (state)
        GRD_SHUT: begin
          if (wr_key && key_data == KEY_ARM) state <= GRD_HALF;
        end
        GRD_HALF: begin
          if (wr_prot) begin
            if (wr_key && key_data == KEY_OPEN)     state <= GRD_OPEN;
            else if (wr_key && key_data == KEY_ARM) state <= GRD_HALF;
            else                                    state <= GRD_SHUT;
          end
        end
        GRD_OPEN: begin
          if (wr_prot) state <= GRD_SHUT;
        end
        default: state <= GRD_SHUT;
      endcase
    end
  end

endmodule

// File: rtl/dsw_prescaler.sv
`timescale 1ns/1ps
// Free-running divider, held at zero while stopped or restarted.
module dsw_prescaler #(
  parameter int SLOW_SHIFT = 15,
  parameter int FAST_SHIFT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic fast,
  output logic tick_o
);

  localparam int CW = (SLOW_SHIFT > FAST_SHIFT) ? SLOW_SHIFT : FAST_SHIFT;

  logic [CW-1:0] cnt;
  logic          slow_hit;
  logic          fast_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!run || restart)  cnt <= '0;
    else                       cnt <= cnt + CW'(1);
  end

  assign slow_hit = &cnt[SLOW_SHIFT-1:0];
  assign fast_hit = &cnt[FAST_SHIFT-1:0];
  assign tick_o   = run & ~restart & (fast ? fast_hit : slow_hit);

endmodule

// File: rtl/dsw_stage_engine.sv
`timescale 1ns/1ps
// Two cascaded countdown stages; stage 1 may self-reload in timer mode.
module dsw_stage_engine
  import dsw_pkg::*;
#(
  parameter int               PRE_W    = 20,
  parameter logic [PRE_W-1:0] PRE_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             reload,
  input  logic             timer_mode,
  input  logic             tick,
  input  logic [PRE_W-1:0] pre1,
  input  logic [PRE_W-1:0] pre2,
  output logic             s1_exp_o,
  output logic             s2_exp_o,
  output logic             fired_o
);

  stage_e           stage;
  logic [PRE_W-1:0] cnt1;
  logic [PRE_W-1:0] cnt2;
  logic             in_one;
  logic             live;

  assign in_one   = (stage == STG_IDLE) || (stage == STG_ONE);
  assign live     = run & ~reload & tick;
  assign s1_exp_o = live & in_one & (cnt1 <= PRE_W'(1));
  assign s2_exp_o = live & ~timer_mode & (stage == STG_TWO) & (cnt2 <= PRE_W'(1));
  assign fired_o  = (stage == STG_FIRED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= STG_IDLE;
      cnt1  <= PRE_INIT;
      cnt2  <= PRE_INIT;
    end else if (!run) begin
      stage <= STG_IDLE;
      cnt1  <= pre1;
      cnt2  <= pre2;
    end else if (reload) begin
      stage <= STG_ONE;
      cnt1  <= pre1;
      cnt2  <= pre2;
    end else begin
      unique case (stage)
        STG_IDLE, STG_ONE: begin
          stage <= STG_ONE;
          if (tick) begin
            if (cnt1 <= PRE_W'(1)) begin
              if (timer_mode) cnt1  <= pre1;
              else            stage <= STG_TWO;
            end else begin
              cnt1 <= cnt1 - PRE_W'(1);
            end
          end
        end
        STG_TWO: begin
          if (timer_mode) begin
            stage <= STG_ONE;
            cnt1  <= pre1;
          end else if (tick) begin
            if (cnt2 <= PRE_W'(1)) stage <= STG_FIRED;
            else                   cnt2  <= cnt2 - PRE_W'(1);
          end
        end
        STG_FIRED: begin
          stage <= STG_FIRED;
        end
        default: stage <= STG_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dual_stage_watchdog.sv
`timescale 1ns/1ps
// Register file, decode and outputs of the two-stage watchdog.
module dual_stage_watchdog
  import dsw_pkg::*;
#(
  parameter int               ADDR_W     = 5,
  parameter int               DATA_W     = 32,   // must exceed PRE_W
  parameter int               PRE_W      = 20,
  parameter int               SLOW_SHIFT = 15,
  parameter int               FAST_SHIFT = 5,
  parameter logic [PRE_W-1:0] PRE_INIT   = PRE_W'(30 << 9)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              nmi_o,
  output logic              wdt_rst_o
);

  logic blk_rst_n;
  assign blk_rst_n = rst_n & por_n;

  // decode
  logic wr, rd;
  logic hit_pre1, hit_pre2, hit_stat, hit_rld, hit_cfg, hit_lock;
  logic wr_prot, guard_open, accept, kick, flag_clr;

  assign wr       = bus_sel & bus_we;
  assign rd       = bus_sel & ~bus_we;
  assign hit_pre1 = (bus_addr == ADDR_W'(OFS_PRE1));
  assign hit_pre2 = (bus_addr == ADDR_W'(OFS_PRE2));
  assign hit_stat = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_rld  = (bus_addr == ADDR_W'(OFS_RLD));
  assign hit_cfg  = (bus_addr == ADDR_W'(OFS_CFG));
  assign hit_lock = (bus_addr == ADDR_W'(OFS_LOCK));
  assign wr_prot  = wr & (hit_pre1 | hit_pre2 | hit_rld);

  dsw_unlock_guard i_guard (
    .clk      (clk),
    .rst_n    (blk_rst_n),
    .wr_key   (wr & hit_rld),
    .key_data (bus_wdata[KEY_W-1:0]),
    .wr_prot  (wr_prot),
    .open_o   (guard_open),
    .accept_o (accept)
  );

  assign kick     = accept & hit_rld & bus_wdata[BIT_KICK];
  assign flag_clr = accept & hit_rld & bus_wdata[BIT_FLAG];

  // register file
  logic [PRE_W-1:0] pre1, pre2;
  logic             cfg_norst, cfg_fast;
  irq_kind_e        cfg_irq;
  logic             lck_en, lck_lock, lck_mode;
  logic             st_irq, pulse_q, timeout_flag;
  logic             tick, s1_exp, s2_exp, fired;

  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n) begin
      pre1 <= PRE_INIT;
      pre2 <= PRE_INIT;
    end else if (accept) begin
      if (hit_pre1) pre1 <= bus_wdata[PRE_W-1:0];
      if (hit_pre2) pre2 <= bus_wdata[PRE_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n) begin
      cfg_norst <= 1'b0;
      cfg_fast  <= 1'b0;
      cfg_irq   <= IRQ_LEVEL;
    end else if (wr && hit_cfg) begin
      cfg_norst <= bus_wdata[BIT_NORST];
      cfg_fast  <= bus_wdata[BIT_FAST];
      cfg_irq   <= irq_kind_e'(bus_wdata[1:0]);
    end
  end

  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n) begin
      lck_en   <= 1'b0;
      lck_lock <= 1'b0;
      lck_mode <= 1'b0;
    end else if (wr && hit_lock && !lck_lock) begin
      lck_en   <= bus_wdata[BIT_EN];
      lck_lock <= bus_wdata[BIT_LOCK];
      lck_mode <= bus_wdata[BIT_MODE];
    end
  end

  always_ff @(posedge clk or negedge blk_rst_n) begin
    if (!blk_rst_n) begin
      st_irq  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      if (s1_exp && cfg_irq != IRQ_NONE)           st_irq <= 1'b1;
      else if (wr && hit_stat && bus_wdata[BIT_STAT]) st_irq <= 1'b0;
      pulse_q <= s1_exp && (cfg_irq == IRQ_PULSE);
    end
  end

  // survives the system reset, cleared only at power-on
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        timeout_flag <= 1'b0;
    else if (s2_exp)   timeout_flag <= 1'b1;
    else if (flag_clr) timeout_flag <= 1'b0;
  end

  dsw_prescaler #(
    .SLOW_SHIFT (SLOW_SHIFT),
    .FAST_SHIFT (FAST_SHIFT)
  ) i_presc (
    .clk     (clk),
    .rst_n   (blk_rst_n),
    .run     (lck_en),
    .restart (kick),
    .fast    (cfg_fast),
    .tick_o  (tick)
  );

  dsw_stage_engine #(
    .PRE_W    (PRE_W),
    .PRE_INIT (PRE_INIT)
  ) i_engine (
    .clk        (clk),
    .rst_n      (blk_rst_n),
    .run        (lck_en),
    .reload     (kick),
    .timer_mode (lck_mode),
    .tick       (tick),
    .pre1       (pre1),
    .pre2       (pre2),
    .s1_exp_o   (s1_exp),
    .s2_exp_o   (s2_exp),
    .fired_o    (fired)
  );

  // outputs
  assign irq_o     = ((cfg_irq == IRQ_LEVEL) & st_irq) | pulse_q;
  assign nmi_o     = (cfg_irq == IRQ_NMI) & st_irq;
  assign wdt_rst_o = fired & ~cfg_norst;

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit_pre1) bus_rdata[PRE_W-1:0] = pre1;
      if (hit_pre2) bus_rdata[PRE_W-1:0] = pre2;
      if (hit_stat) bus_rdata[BIT_STAT]  = st_irq;
      if (hit_rld)  bus_rdata[BIT_FLAG]  = timeout_flag;
      if (hit_cfg) begin
        bus_rdata[BIT_NORST] = cfg_norst;
        bus_rdata[BIT_FAST]  = cfg_fast;
        bus_rdata[1:0]       = cfg_irq;
      end
      if (hit_lock) begin
        bus_rdata[BIT_EN]   = lck_en;
        bus_rdata[BIT_LOCK] = lck_lock;
        bus_rdata[BIT_MODE] = lck_mode;
      end
    end
  end

  logic unused_hi;
  assign unused_hi = ^bus_wdata[DATA_W-1:PRE_W];

endmodule

// File: rtl/dual_stage_watchdog_chk.sv
`timescale 1ns/1ps
module dual_stage_watchdog_chk
  import dsw_pkg::*;
(
  input logic      clk,
  input logic      blk_rst_n,
  input logic      por_n,
  input logic      lck_en,
  input logic      lck_lock,
  input logic      timeout_flag,
  input logic      flag_clr,
  input logic      s2_exp,
  input logic      guard_open,
  input logic      wr_prot,
  input logic      irq_o,
  input irq_kind_e cfg_irq,
  input logic      wdt_rst_o
);

  // R2: an open guard admits a single protected write
  p_single_write_r2: assert property (@(posedge clk) disable iff (!blk_rst_n)
    (guard_open && wr_prot) |=> !guard_open);

  // R8: lock keeps itself and the enable bit frozen
  p_lock_holds_r8: assert property (@(posedge clk) disable iff (!blk_rst_n)
    lck_lock |=> (lck_lock && $stable(lck_en)));

  // R7: flag persists unless a guarded clear arrives
  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
    (timeout_flag && !flag_clr) |=> timeout_flag);

  // R5: stage-2 expiry records the timeout
  p_flag_sets_r5: assert property (@(posedge clk) disable iff (!por_n)
    s2_exp |=> timeout_flag);

  // R9: a disabled block never requests a reset
  p_quiet_when_off_r9: assert property (@(posedge clk) disable iff (!blk_rst_n)
    (!lck_en && !$past(lck_en)) |-> !wdt_rst_o);

  // R4: pulse style lasts one cycle
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!blk_rst_n)
    (irq_o && cfg_irq == IRQ_PULSE) |=> (!irq_o || cfg_irq != IRQ_PULSE));

endmodule

bind dual_stage_watchdog dual_stage_watchdog_chk i_chk (.*);

// File: tb/test_dual_stage_watchdog.sv
`timescale 1ns/1ps
module test_dual_stage_watchdog;
  import dsw_pkg::*;

  localparam int AW = 5;
  localparam int DW = 32;
  localparam int PW = 20;
  localparam int SS = 3;
  localparam int FS = 1;
  localparam int DSLOW = 1 << SS;
  localparam int DFAST = 1 << FS;
  localparam logic [31:0] INIT_PRE = 32'd15360;

  logic          clk = 1'b0;
  logic          por_n = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o, nmi_o, wdt_rst_o;

  int vectors = 0;
  int fails   = 0;
  int p1v [4] = '{1, 2, 3, 5};
  int p2v [3] = '{1, 3, 4};

  always #4 clk = ~clk;

  dual_stage_watchdog #(
    .ADDR_W (AW), .DATA_W (DW), .PRE_W (PW),
    .SLOW_SHIFT (SS), .FAST_SHIFT (FS)
  ) i_dual_stage_watchdog (
    .clk (clk), .por_n (por_n), .rst_n (rst_n),
    .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .irq_o (irq_o), .nmi_o (nmi_o), .wdt_rst_o (wdt_rst_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = AW'(a);
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic unlock();
    bus_write(OFS_RLD, 32'h80);
    bus_write(OFS_RLD, 32'h86);
  endtask

  task automatic prot_write(input int a, input logic [31:0] d);
    unlock();
    bus_write(a, d);
  endtask

  task automatic sys_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic power_reset();
    @(negedge clk); por_n = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog (all requirements): run did not complete, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] rv;
    int n, n1, n2, hits;

    power_reset();
    // R1 reset state
    bus_read(OFS_PRE1, rv); check("R1", "pre1 reset", rv, INIT_PRE);
    bus_read(OFS_PRE2, rv); check("R1", "pre2 reset", rv, INIT_PRE);
    bus_read(OFS_STAT, rv); check("R1", "status reset", rv, 0);
    bus_read(OFS_RLD,  rv); check("R1", "reload reset", rv, 0);
    bus_read(OFS_CFG,  rv); check("R1", "config reset", rv, 0);
    bus_read(OFS_LOCK, rv); check("R1", "lock reset", rv, 0);
    check("R1", "outputs reset", {29'd0, irq_o, nmi_o, wdt_rst_o}, 0);

    // R3 unguarded and broken sequences
    bus_write(OFS_PRE1, 7);
    bus_read(OFS_PRE1, rv); check("R3", "unguarded write", rv, INIT_PRE);
    bus_write(OFS_RLD, 32'h80); bus_write(OFS_RLD, 32'h55); bus_write(OFS_PRE1, 7);
    bus_read(OFS_PRE1, rv); check("R3", "wrong second key", rv, INIT_PRE);
    bus_write(OFS_RLD, 32'h80); bus_write(OFS_PRE2, 7); bus_write(OFS_PRE2, 7);
    bus_read(OFS_PRE2, rv); check("R3", "write between keys", rv, INIT_PRE);

    // R2 one write per unlock
    prot_write(OFS_PRE1, 9);
    bus_read(OFS_PRE1, rv); check("R2", "guarded write", rv, 9);
    bus_write(OFS_PRE1, 11);
    bus_read(OFS_PRE1, rv); check("R2", "second write refused", rv, 9);
    bus_write(OFS_RLD, 32'h80); bus_write(OFS_RLD, 32'h80); bus_write(OFS_RLD, 32'h86);
    bus_write(OFS_PRE1, 11);
    bus_read(OFS_PRE1, rv); check("R2", "rearmed first key", rv, 11);

    // R9 disabled block stays quiet
    prot_write(OFS_PRE1, 1); prot_write(OFS_PRE2, 1);
    bus_write(OFS_CFG, 32'h4);
    hits = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      hits += int'(irq_o | nmi_o | wdt_rst_o);
    end
    check("R9", "outputs while disabled", hits, 0);
    bus_read(OFS_RLD, rv); check("R9", "no flag while disabled", rv, 0);

    // R4 R5 R10 sweep: preloads x tick rates
    for (int f = 0; f < 2; f++) begin
      for (int i = 0; i < 4; i++) begin
        for (int j = 0; j < 3; j++) begin
          int d;
          d = (f != 0) ? DFAST : DSLOW;
          sys_reset();
          prot_write(OFS_PRE1, p1v[i]);
          prot_write(OFS_PRE2, p2v[j]);
          bus_write(OFS_CFG, f << BIT_FAST);
          bus_write(OFS_LOCK, 1 << BIT_EN);
          n = 0; n1 = -1; n2 = -1;
          while (n2 < 0 && n < 400) begin
            @(negedge clk); n++;
            if (irq_o && n1 < 0) n1 = n;
            if (wdt_rst_o) n2 = n;
          end
          check("R4/R10", "stage-1 cycles", n1, d * p1v[i]);
          check("R5/R10", "stage-2 cycles", n2, d * (p1v[i] + p2v[j]));
          bus_read(OFS_RLD, rv); check("R5", "timeout flag set", rv, 32'h200);
        end
      end
    end

    // R7 flag survives system reset, clears only when guarded or at power-on
    sys_reset();
    bus_read(OFS_RLD, rv); check("R7", "flag after rst_n", rv, 32'h200);
    check("R7", "reset output after rst_n", wdt_rst_o, 0);
    bus_write(OFS_RLD, 32'h200);
    bus_read(OFS_RLD, rv); check("R7", "unguarded clear ignored", rv, 32'h200);
    prot_write(OFS_RLD, 32'h200);
    bus_read(OFS_RLD, rv); check("R7", "guarded clear", rv, 0);

    // R5 reset output masked by config bit 5
    prot_write(OFS_PRE1, 1); prot_write(OFS_PRE2, 1);
    bus_write(OFS_CFG, 32'h24);
    bus_write(OFS_LOCK, 1 << BIT_EN);
    hits = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      hits += int'(wdt_rst_o);
    end
    check("R5", "masked reset output", hits, 0);
    bus_read(OFS_RLD, rv); check("R5", "flag with mask", rv, 32'h200);
    power_reset();
    bus_read(OFS_RLD, rv); check("R7", "flag after por_n", rv, 0);

    // R4 R12 level style and status clear
    prot_write(OFS_PRE1, 2); prot_write(OFS_PRE2, 30);
    bus_write(OFS_CFG, 32'h4);
    bus_write(OFS_LOCK, 1 << BIT_EN);
    repeat (8) @(negedge clk);
    check("R4", "level irq", {30'd0, irq_o, nmi_o}, 2);
    bus_write(OFS_STAT, 1);
    #1 check("R12", "irq after clear", irq_o, 0);
    bus_read(OFS_STAT, rv); check("R12", "status after clear", rv, 0);

    // R4 pulse style
    sys_reset();
    prot_write(OFS_PRE1, 2); prot_write(OFS_PRE2, 30);
    bus_write(OFS_CFG, 32'h5);
    bus_write(OFS_LOCK, 1 << BIT_EN);
    hits = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      hits += int'(irq_o);
    end
    check("R4", "pulse count", hits, 1);
    bus_read(OFS_STAT, rv); check("R4", "status on pulse style", rv, 1);

    // R4 non-maskable style
    sys_reset();
    prot_write(OFS_PRE1, 2); prot_write(OFS_PRE2, 30);
    bus_write(OFS_CFG, 32'h6);
    bus_write(OFS_LOCK, 1 << BIT_EN);
    repeat (8) @(negedge clk);
    check("R4", "nmi style", {30'd0, irq_o, nmi_o}, 1);

    // R4 interrupt disabled
    sys_reset();
    prot_write(OFS_PRE1, 2); prot_write(OFS_PRE2, 30);
    bus_write(OFS_CFG, 32'h7);
    bus_write(OFS_LOCK, 1 << BIT_EN);
    repeat (8) @(negedge clk);
    check("R4", "type 11 outputs", {30'd0, irq_o, nmi_o}, 0);
    bus_read(OFS_STAT, rv); check("R4", "type 11 status", rv, 0);

    // R6 keepalive
    sys_reset();
    prot_write(OFS_PRE1, 4); prot_write(OFS_PRE2, 4);
    bus_write(OFS_LOCK, 1 << BIT_EN);
    for (int r = 0; r < 3; r++) begin
      repeat (20) @(negedge clk);
      prot_write(OFS_RLD, 32'h100);
    end
    check("R6", "no expiry with keepalive", irq_o, 0);
    n = 0; n1 = -1;
    while (n1 < 0 && n < 200) begin
      if (n == 10) begin
        bus_write(OFS_RLD, 32'h100);
        n += 2;
      end else begin
        @(negedge clk); n++;
      end
      if (irq_o) n1 = n;
    end
    check("R6", "expiry after last guarded kick", n1, DSLOW * 4);

    // R8 lock
    sys_reset();
    bus_write(OFS_LOCK, 32'h3);
    bus_write(OFS_LOCK, 32'h0);
    bus_read(OFS_LOCK, rv); check("R8", "clear refused", rv, 3);
    bus_write(OFS_LOCK, 32'h4);
    bus_read(OFS_LOCK, rv); check("R8", "mode change refused", rv, 3);
    sys_reset();
    bus_read(OFS_LOCK, rv); check("R8", "lock after reset", rv, 0);

    // R11 timer mode
    prot_write(OFS_PRE1, 3); prot_write(OFS_PRE2, 1);
    bus_write(OFS_CFG, 32'h5);
    bus_write(OFS_LOCK, 32'h6);
    hits = 0; n2 = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      hits += int'(irq_o);
      n2   += int'(wdt_rst_o);
    end
    check("R11", "periodic pulses", hits, 10);
    check("R11", "no reset in timer mode", n2, 0);
    bus_read(OFS_RLD, rv); check("R11", "flag untouched", rv, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule